// File: doc/BRIEF.md
# Dual-Master GPIO Output Level Register

This block holds the output levels for thirty general-purpose pins and drives them straight to the pad ring. Two bus masters, each standing for one processor core, share the register. Every master has its own simple write port: a valid strobe, an address offset inside a four-word alias window, and a 32-bit data word. The offset selects what the write does. It can replace the stored value, set the bits marked in the data, clear them, or flip them.

Both masters may write in the same clock cycle. Neither write wins arbitration. The update from master 0 is applied to the stored value first, and the update from master 1 is then applied to that intermediate result. A read port always returns the stored value, never the levels seen on the pins.

Top module: `gpio_dual_drive`

## Requirements
- R1: A low `rst_n` at a rising clock edge sets all 30 stored bits to zero, even when either master writes in that cycle.
- R2: A plain write (address bits [3:2] = 2'b00) stores data bits [29:0] at the next rising edge.
- R3: A set write (address bits [3:2] = 2'b10) forces the stored bits to 1 wherever the data bit is 1, and leaves the other bits alone.
- R4: A clear write (address bits [3:2] = 2'b11) forces the stored bits to 0 wherever the data bit is 1, and leaves the other bits alone.
- R5: A toggle write (address bits [3:2] = 2'b01) inverts the stored bits wherever the data bit is 1.
- R6: Only address bits [3:2] choose the operation. Address bits [1:0] have no effect.
- R7: When both masters write in one cycle, the new value equals master 1's operation applied to the result of master 0's operation on the old value.
- R8: A plain write from master 1 sets the new value to master 1's data, whatever master 0 does in the same cycle.
- R9: Data bits [31:30] are ignored on every write, and `rd_data[31:30]` always reads zero.
- R10: `pad_out` and `rd_data[29:0]` both show the stored value. The stored value holds in any cycle with no valid write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates occur on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| m0_wr_valid | input | 1 | Master 0 write strobe |
| m0_wr_addr | input | 4 | Master 0 byte offset in the alias window; bits [3:2] select the operation |
| m0_wr_data | input | 32 | Master 0 write data; bits [29:0] are used |
| m1_wr_valid | input | 1 | Master 1 write strobe |
| m1_wr_addr | input | 4 | Master 1 byte offset in the alias window; bits [3:2] select the operation |
| m1_wr_data | input | 32 | Master 1 write data; bits [29:0] are used |
| rd_data | output | 32 | Stored value, zero-extended to 32 bits |
| pad_out | output | 30 | Output levels to the pads; 1 drives high |

## Verification
The bench walks all sixteen same-cycle pairings of the four operations. It uses data patterns chosen to overlap, so a design that applied master 1 before master 0, or that dropped one of the two writes, returns a different word. Directed cases cover the following:
- A master 1 plain write over a master 0 set, which a merge-style design would corrupt.
- Writes with all 32 data bits high, which would leak into `rd_data[31:30]` in a design that kept the top bits.
- Address offsets with nonzero low bits, which a decoder using the wrong bits would map to the wrong operation.
- A reset asserted during an active write, which a design that gave writes priority would lose.

Random operation pairs are then compared against an independent model.

// File: rtl/gpio_dual_pkg.sv
// Package: operation codes shared by the alias decoder, the update stage
// and the top. Assumes a four-word alias window per master.
package gpio_dual_pkg;
    typedef enum logic [1:0] {
        OP_PLAIN = 2'b00,
        OP_FLIP  = 2'b01,
        OP_SET   = 2'b10,
        OP_CLR   = 2'b11
    } wr_op_e;
endpackage

// File: rtl/gpio_alias_decode.sv
// Module: turns one master's raw write port into an enable, an operation
// and a pin mask. Assumes the operation code sits at address bits
// [OP_LSB+1:OP_LSB]; all other address bits and the data bits above
// NUM_PINS are ignored.
module gpio_alias_decode
    import gpio_dual_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int OP_LSB   = 2,
    parameter int BUS_W    = 32,
    parameter int NUM_PINS = 30
) (
    input  logic                wr_valid,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BUS_W-1:0]    wr_data,
    output logic                upd_en,
    output wr_op_e              upd_op,
    output logic [NUM_PINS-1:0] upd_mask
);
    localparam int OP_W = 2;

    // Pass the strobe through and slice out the operation and the pin bits.
    always_comb begin
        upd_en   = wr_valid;
        upd_op   = wr_op_e'(wr_addr[OP_LSB +: OP_W]);
        upd_mask = wr_data[NUM_PINS-1:0];
    end

    // Fold the ignored address and data bits into sinks, so that leaving
    // them out is visibly deliberate.
    logic unused_addr_bits;
    logic unused_data_bits;
    generate
        if (OP_LSB > 0) begin : g_low_addr
            if (ADDR_W > OP_LSB + OP_W) begin : g_both
                assign unused_addr_bits = ^{wr_addr[ADDR_W-1:OP_LSB+OP_W], wr_addr[OP_LSB-1:0]};
            end else begin : g_low_only
                assign unused_addr_bits = ^wr_addr[OP_LSB-1:0];
            end
        end else if (ADDR_W > OP_W) begin : g_high_addr
            assign unused_addr_bits = ^wr_addr[ADDR_W-1:OP_W];
        end else begin : g_no_addr
            assign unused_addr_bits = 1'b0;
        end
        if (BUS_W > NUM_PINS) begin : g_high_data
            assign unused_data_bits = ^wr_data[BUS_W-1:NUM_PINS];
        end else begin : g_no_data
            assign unused_data_bits = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/gpio_op_apply.sv
// Module: applies one master's update to an incoming pin vector. It is
// purely combinational. Assumes the update is skipped when upd_en is low.
module gpio_op_apply
    import gpio_dual_pkg::*;
#(
    parameter int NUM_PINS = 30
) (
    input  logic [NUM_PINS-1:0] cur_val,
    input  logic                upd_en,
    input  wr_op_e              upd_op,
    input  logic [NUM_PINS-1:0] upd_mask,
    output logic [NUM_PINS-1:0] nxt_val
);
    // Select the new value for the enabled operation.
    always_comb begin
        nxt_val = cur_val;
        if (upd_en) begin
            unique case (upd_op)
                OP_PLAIN: nxt_val = upd_mask;
                OP_FLIP:  nxt_val = cur_val ^ upd_mask;
                OP_SET:   nxt_val = cur_val | upd_mask;
                OP_CLR:   nxt_val = cur_val & ~upd_mask;
                default:  nxt_val = cur_val;
            endcase
        end
    end
endmodule

// File: rtl/gpio_dual_drive.sv
// Module: GPIO output-level register shared by two masters. The update
// stages are chained in master order, so master 0's result feeds master
// 1's stage, and the end of the chain loads the register. Assumes a
// synchronous active-low reset and a single clock for both masters.
module gpio_dual_drive
    import gpio_dual_pkg::*;
#(
    parameter int NUM_PINS = 30,
    parameter int BUS_W    = 32,
    parameter int ADDR_W   = 4,
    parameter int OP_LSB   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                m0_wr_valid,
    input  logic [ADDR_W-1:0]   m0_wr_addr,
    input  logic [BUS_W-1:0]    m0_wr_data,
    input  logic                m1_wr_valid,
    input  logic [ADDR_W-1:0]   m1_wr_addr,
    input  logic [BUS_W-1:0]    m1_wr_data,
    output logic [BUS_W-1:0]    rd_data,
    output logic [NUM_PINS-1:0] pad_out
);
    localparam int NUM_MASTERS = 2;
    localparam int PAD_W       = BUS_W - NUM_PINS;

    logic                          port_valid [NUM_MASTERS];
    logic [ADDR_W-1:0]             port_addr  [NUM_MASTERS];
    logic [BUS_W-1:0]              port_data  [NUM_MASTERS];
    logic                          dec_en     [NUM_MASTERS];
    wr_op_e                        dec_op     [NUM_MASTERS];
    logic [NUM_PINS-1:0]           dec_mask   [NUM_MASTERS];
    logic [NUM_PINS-1:0]           chain      [NUM_MASTERS+1];
    logic [NUM_PINS-1:0]           level_q;

    // Gather the per-master ports into arrays indexed by master number.
    always_comb begin
        port_valid[0] = m0_wr_valid;
        port_addr[0]  = m0_wr_addr;
        port_data[0]  = m0_wr_data;
        port_valid[1] = m1_wr_valid;
        port_addr[1]  = m1_wr_addr;
        port_data[1]  = m1_wr_data;
    end

    assign chain[0] = level_q;

    generate
        for (genvar gi = 0; gi < NUM_MASTERS; gi++) begin : g_master
            gpio_alias_decode #(
                .ADDR_W   (ADDR_W),
                .OP_LSB   (OP_LSB),
                .BUS_W    (BUS_W),
                .NUM_PINS (NUM_PINS)
            ) dec_i (
                .wr_valid (port_valid[gi]),
                .wr_addr  (port_addr[gi]),
                .wr_data  (port_data[gi]),
                .upd_en   (dec_en[gi]),
                .upd_op   (dec_op[gi]),
                .upd_mask (dec_mask[gi])
            );
            gpio_op_apply #(
                .NUM_PINS (NUM_PINS)
            ) app_i (
                .cur_val  (chain[gi]),
                .upd_en   (dec_en[gi]),
                .upd_op   (dec_op[gi]),
                .upd_mask (dec_mask[gi]),
                .nxt_val  (chain[gi+1])
            );
        end
    endgenerate

    // Load the chained result, or clear it during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= chain[NUM_MASTERS];
    end

    // Drive the pads and the read port straight from the register flops.
    always_comb begin
        pad_out = level_q;
        rd_data = {{PAD_W{1'b0}}, level_q};
    end

    // R1: reset wins over any write in the same cycle.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pad_out == '0));

    // R8: a master 1 plain write decides the new value on its own.
    p_m1_plain_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m1_wr_valid && m1_wr_addr[OP_LSB +: 2] == 2'b00)
        |=> (pad_out == $past(m1_wr_data[NUM_PINS-1:0])));

    // R3: a lone master 0 set leaves every masked bit high.
    p_set_lone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m0_wr_valid && !m1_wr_valid && m0_wr_addr[OP_LSB +: 2] == 2'b10)
        |=> ((pad_out & $past(m0_wr_data[NUM_PINS-1:0])) == $past(m0_wr_data[NUM_PINS-1:0])));

    // R4: a lone master 0 clear leaves every masked bit low.
    p_clr_lone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m0_wr_valid && !m1_wr_valid && m0_wr_addr[OP_LSB +: 2] == 2'b11)
        |=> ((pad_out & $past(m0_wr_data[NUM_PINS-1:0])) == '0));

    // R10: with no write the pads keep their level.
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !m0_wr_valid && !m1_wr_valid) |=> $stable(pad_out));

    // R9: the top read bits never carry data.
    p_read_top_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BUS_W-1:NUM_PINS] == '0);
endmodule

// File: tb/gpio_dual_drive_tb.sv
`timescale 1ns/1ps
module gpio_dual_drive_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m0_wr_valid = 1'b0;
    logic [3:0]  m0_wr_addr = '0;
    logic [31:0] m0_wr_data = '0;
    logic        m1_wr_valid = 1'b0;
    logic [3:0]  m1_wr_addr = '0;
    logic [31:0] m1_wr_data = '0;
    logic [31:0] rd_data;
    logic [29:0] pad_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [29:0] ref_val = '0;

    // Data patterns for the operation-pair sweep.
    localparam logic [31:0] PAT [8] = '{
        32'hFFFF_0000, 32'h0F0F_F0F0, 32'h3FFF_FFFF, 32'hC000_0001,
        32'h1234_5678, 32'h2AAA_AAAA, 32'h1555_5555, 32'h0000_FFFF
    };

    always #2.5 clk = ~clk;

    gpio_dual_drive dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .m0_wr_valid (m0_wr_valid),
        .m0_wr_addr  (m0_wr_addr),
        .m0_wr_data  (m0_wr_data),
        .m1_wr_valid (m1_wr_valid),
        .m1_wr_addr  (m1_wr_addr),
        .m1_wr_data  (m1_wr_data),
        .rd_data     (rd_data),
        .pad_out     (pad_out)
    );

    // Reference model of one operation; address bits [3:2] pick it.
    function automatic logic [29:0] mdl(input logic [29:0] c, input logic [3:0] a,
                                        input logic [31:0] d);
        case (a[3:2])
            2'b00:   return d[29:0];
            2'b01:   return c ^ d[29:0];
            2'b10:   return c | d[29:0];
            default: return c & ~d[29:0];
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Apply one cycle of writes, update the model, check both outputs.
    task automatic step(input logic v0, input logic [3:0] a0, input logic [31:0] d0,
                        input logic v1, input logic [3:0] a1, input logic [31:0] d1,
                        input string tag);
        m0_wr_valid = v0; m0_wr_addr = a0; m0_wr_data = d0;
        m1_wr_valid = v1; m1_wr_addr = a1; m1_wr_data = d1;
        @(posedge clk);
        if (!rst_n) ref_val = '0;
        else begin
            if (v0) ref_val = mdl(ref_val, a0, d0);
            if (v1) ref_val = mdl(ref_val, a1, d1);
        end
        @(negedge clk);
        m0_wr_valid = 1'b0;
        m1_wr_valid = 1'b0;
        chk({tag, " rd"}, rd_data, {2'b00, ref_val});
        chk({tag, " pad"}, {2'b00, pad_out}, {2'b00, ref_val});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset rd", rd_data, 32'h0);
        chk("R1 reset pad", {2'b00, pad_out}, 32'h0);
        rst_n = 1'b1;

        // Single-master operations, each master alone.
        step(1, 4'h0, 32'h0000_00FF, 0, 4'h0, 32'h0, "R2 m0 plain");
        step(1, 4'h8, 32'h0000_0F00, 0, 4'h0, 32'h0, "R3 m0 set");
        step(1, 4'hC, 32'h0000_000F, 0, 4'h0, 32'h0, "R4 m0 clr");
        step(1, 4'h4, 32'h0000_FFFF, 0, 4'h0, 32'h0, "R5 m0 xor");
        step(0, 4'h0, 32'h0, 1, 4'h0, 32'h2468_ACE0, "R2 m1 plain");
        step(0, 4'h0, 32'h0, 1, 4'h8, 32'h0000_0003, "R3 m1 set");
        step(0, 4'h0, 32'h0, 1, 4'hC, 32'h2000_0000, "R4 m1 clr");
        step(0, 4'h0, 32'h0, 1, 4'h4, 32'h3FFF_FFFF, "R5 m1 xor");

        // R7: every pairing of the four operations in one cycle, offsets
        // carrying nonzero low bits to exercise R6 as well.
        for (int o0 = 0; o0 < 4; o0++) begin
            for (int o1 = 0; o1 < 4; o1++) begin
                int idx = o0 * 4 + o1;
                step(1, {o0[1:0], idx[1:0]}, PAT[idx % 8],
                     1, {o1[1:0], idx[3:2]}, PAT[(idx + 3) % 8], "R7 pair");
            end
        end

        // R8: master 1 plain overrides a master 0 set.
        step(1, 4'h0, 32'h0000_0000, 0, 4'h0, 32'h0, "R2 prep");
        step(1, 4'h8, 32'h3FFF_0000, 1, 4'h0, 32'h0000_1111, "R8 override");
        chk("R8 value", rd_data, 32'h0000_1111);

        // R6: offset 0x5 is a toggle, offset 0xB is a set.
        step(1, 4'h5, 32'h0000_1010, 0, 4'h0, 32'h0, "R6 low bits xor");
        chk("R6 xor value", rd_data, 32'h0000_0101);
        step(0, 4'h0, 32'h0, 1, 4'hB, 32'h0001_0000, "R6 low bits set");
        chk("R6 set value", rd_data, 32'h0001_0101);

        // R9: top data bits are dropped.
        step(1, 4'h0, 32'hFFFF_FFFF, 0, 4'h0, 32'h0, "R9 all ones");
        chk("R9 top zero", rd_data, 32'h3FFF_FFFF);
        step(0, 4'h0, 32'h0, 1, 4'h4, 32'hC000_0000, "R9 top xor");
        chk("R9 top xor value", rd_data, 32'h3FFF_FFFF);

        // R10: idle cycles hold the value.
        step(0, 4'h0, 32'h0, 0, 4'h0, 32'h0, "R10 idle");
        step(0, 4'hC, 32'hFFFF_FFFF, 0, 4'hC, 32'hFFFF_FFFF, "R10 idle strobes low");
        chk("R10 held", rd_data, 32'h3FFF_FFFF);

        // Random operation pairs against the model.
        for (int k = 0; k < 300; k++) begin
            logic [31:0] r0, r1, rs;
            r0 = $urandom; r1 = $urandom; rs = $urandom;
            step(rs[0], rs[7:4], r0, rs[1], rs[11:8], r1, "R7 random");
        end

        // R1: reset asserted during writes clears the register.
        step(1, 4'h0, 32'h0ABC_DEF0, 0, 4'h0, 32'h0, "R2 before reset");
        rst_n = 1'b0;
        step(1, 4'h8, 32'h3FFF_FFFF, 1, 4'h4, 32'h1111_1111, "R1 reset over writes");
        rst_n = 1'b1;
        step(0, 4'h0, 32'h0, 0, 4'h0, 32'h0, "R1 after release");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule